// File: doc/BRIEF.md
# Debug Halt Control Register File

This block is the memory-mapped control and status register set that a debugger uses to stop, step and inspect a processor core. It sits on a plain 32-bit register bus with a byte offset, a write strobe, write data, a read strobe and combinational read data. The halt control word is protected by a 16-bit key: a write without the key in its upper half changes nothing. The status half of the same word mirrors the core's halted, sleeping, lockup and secure-debug-allowed lines. It also carries three sticky event flags (core reset seen, instruction retired, restart processed), which clear once a bus read has returned them.

A core-register transfer port lets the debugger move one word between a data register and any core register. Writing the selector register launches a one-cycle start pulse toward the core, carrying a 7-bit register number and a direction. It also drops the ready flag. The core answers with a done pulse, which raises the ready flag again and, on a read, captures the core's word into the data register.

Three simpler registers complete the set. One holds vector-catch and monitor controls with reserved bits forced to zero. One holds four authentication override bits. One holds the security state, and its state bit is updated only when its companion key bit is written as zero.

Top module: `dbg_ctl_regs`

## Requirements
- R1: After reset every register reads zero, including the ready flag, and all control outputs are low.
- R2: A write to offset 0x10 whose bits 31:16 differ from 0xA05F leaves every halt control bit unchanged.
- R3: A keyed write to offset 0x10 loads debug enable (bit 0), halt request (bit 1), single step (bit 2), interrupt mask (bit 3) and imprecise entry (bit 5), and drives them to their outputs. Bit 4 and bits 15:6 read as zero.
- R4: Reads of offset 0x10 return the live core lines in bits 17 (halted), 18 (sleeping), 19 (lockup) and 20 (secure debug allowed), and the transfer ready flag in bit 16.
- R5: Bit 25 (core reset seen) and bit 24 (instruction retired) of offset 0x10 set on their input pulses and clear after a read of offset 0x10 returns them. An event in the same cycle as that read leaves the bit set.
- R6: Bit 26 of offset 0x10 sets when a keyed write clears the halt request from 1 to 0, or when the external restart input pulses. The restart input also clears the halt request. The bit clears on read as in R5.
- R7: A write to offset 0x14 produces a one-cycle start pulse in the next cycle, with the selector from bits 6:0 and the direction from bit 16 (1 means write to the core). It also clears the ready flag.
- R8: Offset 0x18 is a readable and writable data register that drives the transfer write data. A done pulse while a transfer is pending sets the ready flag. On a read-direction transfer it also loads the core's word into the data register. A write-direction transfer leaves that register unchanged.
- R9: Offset 0x1C keeps only bits 0, 11:4, 19:16 and 24 of a write (mask 0x010F0FF1) and drives the stored word out.
- R10: Offset 0x24 keeps only bits 3:0 of a write and drives them out.
- R11: At offset 0x28, bits 1:0 always take a write. Bit 16 (security state) takes a write only when bit 17 of the same write is zero. Bit 17 reads as zero.
- R12: Read data is zero whenever the read strobe is low, and on reads of offset 0x14 or of any unmapped offset. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_re |
| core_halted | input | 1 | Core is in debug state |
| core_sleeping | input | 1 | Core is sleeping |
| core_lockup | input | 1 | Core is locked up |
| sec_dbg_allowed | input | 1 | Secure invasive debug is permitted |
| core_reset_evt | input | 1 | Pulse: core was reset |
| core_retire_evt | input | 1 | Pulse: core retired instructions |
| ext_restart_req | input | 1 | Pulse: external request to leave debug state |
| xfer_done | input | 1 | Pulse: core finished the register transfer |
| xfer_rdata | input | 32 | Core register value returned on a read transfer |
| dbg_en | output | 1 | Halting debug enabled |
| halt_req | output | 1 | Halt request to the core |
| step_en | output | 1 | Single-step enable |
| mask_irq | output | 1 | Interrupt mask while debugging |
| imprecise_en | output | 1 | Imprecise debug entry allowed |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| xfer_wr | output | 1 | Transfer direction, 1 writes the core register |
| xfer_sel | output | SEL_W | Core register selector |
| xfer_wdata | output | 32 | Data register contents for a write transfer |
| mon_ctrl | output | 32 | Stored vector-catch and monitor control word |
| auth_ctrl | output | 4 | Authentication override bits |
| sec_state | output | 1 | Current security state bit |
| bank_sel_en | output | 1 | Banked register select enable |
| bank_sel | output | 1 | Banked register select |

## Verification
The bench aims at the guarded writes. A wrong or partial key must leave the control bits alone. A design that checked only part of the key, or applied the low half anyway, would show set control bits on read-back. The security bit must ignore a write that sets its companion bit, and a design that skipped this guard would flip the state. The sticky flags are tested for clear-on-read and for an event that lands in the same cycle as the read. A design that let the clear win would lose that event, and the next read would show zero. For transfers, the bench checks that the start pulse lasts one cycle with the right selector and direction, and that the ready flag drops and comes back. It also checks that only a read-direction done overwrites the data register, so a design that loaded on every done would corrupt the debugger's write value.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;

  localparam int unsigned DW = 32;

  // byte offsets within the block
  localparam int unsigned OFF_HALT = 'h10;
  localparam int unsigned OFF_SEL  = 'h14;
  localparam int unsigned OFF_DATA = 'h18;
  localparam int unsigned OFF_MON  = 'h1C;
  localparam int unsigned OFF_AUTH = 'h24;
  localparam int unsigned OFF_SEC  = 'h28;

  localparam logic [15:0] HALT_KEY = 16'hA05F;

  localparam logic [DW-1:0] MON_MASK  = 32'h010F_0FF1;
  localparam logic [DW-1:0] AUTH_MASK = 32'h0000_000F;

  // halt word bit positions
  localparam int unsigned B_READY   = 16;
  localparam int unsigned B_HALTED  = 17;
  localparam int unsigned B_SLEEP   = 18;
  localparam int unsigned B_LOCKUP  = 19;
  localparam int unsigned B_SECDBG  = 20;
  localparam int unsigned B_STICKY0 = 24;   // retire, reset, restart upward
  localparam int unsigned N_STICKY  = 3;

  // transfer selector fields
  localparam int unsigned B_DIR = 16;
  localparam int unsigned B_SEC_STATE = 16;
  localparam int unsigned B_SEC_GUARD = 17;

  typedef struct packed {
    logic imprecise;
    logic mask_irq;
    logic step;
    logic halt;
    logic en;
  } halt_ctl_t;

endpackage

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
  import dbg_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [15:0]   wkey,
  input  logic [4:0]    wctl,       // {imprecise, mask, step, halt, en}
  input  logic          rd_en,
  input  logic          ready,
  input  logic          core_halted,
  input  logic          core_sleeping,
  input  logic          core_lockup,
  input  logic          sec_dbg_allowed,
  input  logic          core_reset_evt,
  input  logic          core_retire_evt,
  input  logic          ext_restart_req,
  output halt_ctl_t     ctl,
  output logic [DW-1:0] rd_word
);

  halt_ctl_t             ctl_q, ctl_d;
  logic [N_STICKY-1:0]   stk_q, stk_d, stk_set;
  logic                  key_ok, halt_clr_wr;

  always_comb begin
    key_ok      = wr_en && (wkey == HALT_KEY);
    halt_clr_wr = key_ok && ctl_q.halt && !wctl[1];
    ctl_d       = ctl_q;
    if (key_ok) ctl_d = halt_ctl_t'(wctl);
    if (ext_restart_req) ctl_d.halt = 1'b0;
    stk_set = {halt_clr_wr || ext_restart_req, core_reset_evt, core_retire_evt};
  end

  for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
    always_comb stk_d[i] = stk_set[i] | (stk_q[i] & ~rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      stk_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      stk_q <= stk_d;
    end
  end

  always_comb begin
    rd_word                             = '0;
    rd_word[0]                          = ctl_q.en;
    rd_word[1]                          = ctl_q.halt;
    rd_word[2]                          = ctl_q.step;
    rd_word[3]                          = ctl_q.mask_irq;
    rd_word[5]                          = ctl_q.imprecise;
    rd_word[B_READY]                    = ready;
    rd_word[B_HALTED]                   = core_halted;
    rd_word[B_SLEEP]                    = core_sleeping;
    rd_word[B_LOCKUP]                   = core_lockup;
    rd_word[B_SECDBG]                   = sec_dbg_allowed;
    rd_word[B_STICKY0 +: N_STICKY]      = stk_q;
  end

  assign ctl = ctl_q;

endmodule

// File: rtl/dbg_xfer.sv
module dbg_xfer
  import dbg_ctl_pkg::*;
#(
  parameter int unsigned SEL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic             data_wr,
  input  logic [DW-1:0]    wdata,
  input  logic             done,
  input  logic [DW-1:0]    core_rdata,
  output logic             start,
  output logic [SEL_W-1:0] sel,
  output logic             dir_wr,
  output logic [DW-1:0]    data,
  output logic             ready
);

  logic             start_q, start_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             dir_q, dir_d;
  logic [DW-1:0]    data_q, data_d;
  logic             ready_q, ready_d;
  logic             busy_q, busy_d;
  logic             fin;

  always_comb begin
    fin     = done && busy_q;
    start_d = sel_wr;
    sel_d   = sel_wr ? wdata[SEL_W-1:0] : sel_q;
    dir_d   = sel_wr ? wdata[B_DIR]     : dir_q;
    busy_d  = sel_wr ? 1'b1 : (fin ? 1'b0 : busy_q);
    ready_d = sel_wr ? 1'b0 : (fin ? 1'b1 : ready_q);
    data_d  = data_q;
    if (data_wr)          data_d = wdata;
    if (fin && !dir_q)    data_d = core_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      sel_q   <= '0;
      dir_q   <= 1'b0;
      data_q  <= '0;
      ready_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      sel_q   <= sel_d;
      dir_q   <= dir_d;
      data_q  <= data_d;
      ready_q <= ready_d;
      busy_q  <= busy_d;
    end
  end

  assign start  = start_q;
  assign sel    = sel_q;
  assign dir_wr = dir_q;
  assign data   = data_q;
  assign ready  = ready_q;

endmodule

// File: rtl/dbg_mask_reg.sv
module dbg_mask_reg
  import dbg_ctl_pkg::*;
#(
  parameter logic [DW-1:0] MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);

  logic [DW-1:0] q_q, q_d;

  always_comb q_d = we ? (wdata & MASK) : q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;

endmodule

// File: rtl/dbg_sec_reg.sv
module dbg_sec_reg
  import dbg_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          w_guard,
  input  logic          w_state,
  input  logic [1:0]    w_bank,
  output logic          state,
  output logic [1:0]    bank,
  output logic [DW-1:0] rd_word
);

  logic       state_q, state_d;
  logic [1:0] bank_q, bank_d;

  always_comb begin
    state_d = (we && !w_guard) ? w_state : state_q;
    bank_d  = we ? w_bank : bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      bank_q  <= '0;
    end else begin
      state_q <= state_d;
      bank_q  <= bank_d;
    end
  end

  always_comb begin
    rd_word              = '0;
    rd_word[1:0]         = bank_q;
    rd_word[B_SEC_STATE] = state_q;
  end

  assign state = state_q;
  assign bank  = bank_q;

endmodule

// File: rtl/dbg_ctl_regs.sv
module dbg_ctl_regs
  import dbg_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SEL_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_re,
  output logic [DW-1:0]     bus_rdata,
  input  logic              core_halted,
  input  logic              core_sleeping,
  input  logic              core_lockup,
  input  logic              sec_dbg_allowed,
  input  logic              core_reset_evt,
  input  logic              core_retire_evt,
  input  logic              ext_restart_req,
  input  logic              xfer_done,
  input  logic [DW-1:0]     xfer_rdata,
  output logic              dbg_en,
  output logic              halt_req,
  output logic              step_en,
  output logic              mask_irq,
  output logic              imprecise_en,
  output logic              xfer_start,
  output logic              xfer_wr,
  output logic [SEL_W-1:0]  xfer_sel,
  output logic [DW-1:0]     xfer_wdata,
  output logic [DW-1:0]     mon_ctrl,
  output logic [3:0]        auth_ctrl,
  output logic              sec_state,
  output logic              bank_sel_en,
  output logic              bank_sel
);

  localparam logic [ADDR_W-1:0] A_HALT = ADDR_W'(OFF_HALT);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFF_SEL);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(OFF_MON);
  localparam logic [ADDR_W-1:0] A_AUTH = ADDR_W'(OFF_AUTH);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(OFF_SEC);

  logic          wr_halt, wr_sel, wr_data, wr_mon, wr_auth, wr_sec, rd_halt;
  logic          ready;
  halt_ctl_t     ctl;
  logic [DW-1:0] halt_word, sec_word, auth_word, data_word;
  logic [1:0]    bank;

  always_comb begin
    wr_halt = bus_we && (bus_addr == A_HALT);
    wr_sel  = bus_we && (bus_addr == A_SEL);
    wr_data = bus_we && (bus_addr == A_DATA);
    wr_mon  = bus_we && (bus_addr == A_MON);
    wr_auth = bus_we && (bus_addr == A_AUTH);
    wr_sec  = bus_we && (bus_addr == A_SEC);
    rd_halt = bus_re && (bus_addr == A_HALT);
  end

  dbg_halt_ctl u_halt (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_halt),
    .wkey            (bus_wdata[31:16]),
    .wctl            ({bus_wdata[5], bus_wdata[3:0]}),
    .rd_en           (rd_halt),
    .ready           (ready),
    .core_halted     (core_halted),
    .core_sleeping   (core_sleeping),
    .core_lockup     (core_lockup),
    .sec_dbg_allowed (sec_dbg_allowed),
    .core_reset_evt  (core_reset_evt),
    .core_retire_evt (core_retire_evt),
    .ext_restart_req (ext_restart_req),
    .ctl             (ctl),
    .rd_word         (halt_word)
  );

  dbg_xfer #(.SEL_W(SEL_W)) u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_wr     (wr_sel),
    .data_wr    (wr_data),
    .wdata      (bus_wdata),
    .done       (xfer_done),
    .core_rdata (xfer_rdata),
    .start      (xfer_start),
    .sel        (xfer_sel),
    .dir_wr     (xfer_wr),
    .data       (data_word),
    .ready      (ready)
  );

  dbg_mask_reg #(.MASK(MON_MASK)) u_mon (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_mon),
    .wdata (bus_wdata),
    .q     (mon_ctrl)
  );

  dbg_mask_reg #(.MASK(AUTH_MASK)) u_auth (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_auth),
    .wdata (bus_wdata),
    .q     (auth_word)
  );

  dbg_sec_reg u_sec (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_sec),
    .w_guard (bus_wdata[B_SEC_GUARD]),
    .w_state (bus_wdata[B_SEC_STATE]),
    .w_bank  (bus_wdata[1:0]),
    .state   (sec_state),
    .bank    (bank),
    .rd_word (sec_word)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      unique case (bus_addr)
        A_HALT:  bus_rdata = halt_word;
        A_DATA:  bus_rdata = data_word;
        A_MON:   bus_rdata = mon_ctrl;
        A_AUTH:  bus_rdata = auth_word;
        A_SEC:   bus_rdata = sec_word;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign dbg_en       = ctl.en;
  assign halt_req     = ctl.halt;
  assign step_en      = ctl.step;
  assign mask_irq     = ctl.mask_irq;
  assign imprecise_en = ctl.imprecise;
  assign xfer_wdata   = data_word;
  assign auth_ctrl    = auth_word[3:0];
  assign bank_sel_en  = bank[0];
  assign bank_sel     = bank[1];

endmodule

// File: rtl/dbg_ctl_regs_chk.sv
module dbg_ctl_regs_chk
  import dbg_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [15:0]       wkey,
  input logic              bus_re,
  input logic [DW-1:0]     bus_rdata,
  input logic [4:0]        ctl_out,
  input logic              halt_req,
  input logic              ext_restart_req,
  input logic              core_reset_evt,
  input logic              xfer_start,
  input logic              xfer_wr,
  input logic              sec_state,
  input logic [DW-1:0]     status_word
);

  localparam logic [ADDR_W-1:0] A_HALT = ADDR_W'(OFF_HALT);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFF_SEL);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(OFF_SEC);

  p_key_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_HALT && wkey != HALT_KEY && !ext_restart_req)
      |=> $stable(ctl_out));

  p_reset_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset_evt |=> status_word[B_STICKY0 + 1]);

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_restart_req |=> (!halt_req && status_word[B_STICKY0 + 2]));

  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SEL) |=> (xfer_start && xfer_wr == $past(wkey[0])));

  p_start_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_SEL) |=> !xfer_start);

  p_sec_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SEC && wkey[1]) |=> $stable(sec_state));

  p_idle_rdata_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> (bus_rdata == '0));

endmodule

bind dbg_ctl_regs dbg_ctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_addr        (bus_addr),
  .bus_we          (bus_we),
  .wkey            (bus_wdata[31:16]),
  .bus_re          (bus_re),
  .bus_rdata       (bus_rdata),
  .ctl_out         ({imprecise_en, mask_irq, step_en, halt_req, dbg_en}),
  .halt_req        (halt_req),
  .ext_restart_req (ext_restart_req),
  .core_reset_evt  (core_reset_evt),
  .xfer_start      (xfer_start),
  .xfer_wr         (xfer_wr),
  .sec_state       (sec_state),
  .status_word     (halt_word)
);

// File: tb/dbg_ctl_regs_bench.sv
`timescale 1ns/1ps
module dbg_ctl_regs_bench;

  localparam int ADDR_W = 8;
  localparam int SEL_W  = 7;

  typedef struct packed {
    logic [7:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h10, 1'b1, 32'h0000_0003, 32'h0000_0000, 8'd2 },  // R2 no key
    '{8'h10, 1'b1, 32'hA05F_00FF, 32'h0000_002F, 8'd3 },  // R3 layout
    '{8'h10, 1'b1, 32'hA05F_0000, 32'h0400_0000, 8'd6 },  // R6 halt 1->0
    '{8'h10, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 8'd2 },  // R2 wrong key
    '{8'h1C, 1'b1, 32'hFFFF_FFFF, 32'h010F_0FF1, 8'd9 },  // R9
    '{8'h24, 1'b1, 32'hFFFF_FFFF, 32'h0000_000F, 8'd10},  // R10
    '{8'h28, 1'b1, 32'h0003_0003, 32'h0000_0003, 8'd11},  // R11 guarded
    '{8'h28, 1'b1, 32'h0001_0000, 32'h0001_0000, 8'd11},  // R11 open
    '{8'h18, 1'b1, 32'h1234_5678, 32'h1234_5678, 8'd8 },  // R8 data reg
    '{8'h20, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 8'd12},  // R12 unmapped
    '{8'h14, 1'b0, 32'h0000_0000, 32'h0000_0000, 8'd12},  // R12 selector
    '{8'h04, 1'b0, 32'h0000_0000, 32'h0000_0000, 8'd12}   // R12 unmapped
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_we;
  logic [31:0]       bus_wdata;
  logic              bus_re;
  logic [31:0]       bus_rdata;
  logic              core_halted, core_sleeping, core_lockup, sec_dbg_allowed;
  logic              core_reset_evt, core_retire_evt, ext_restart_req;
  logic              xfer_done;
  logic [31:0]       xfer_rdata;
  logic              dbg_en, halt_req, step_en, mask_irq, imprecise_en;
  logic              xfer_start, xfer_wr;
  logic [SEL_W-1:0]  xfer_sel;
  logic [31:0]       xfer_wdata, mon_ctrl;
  logic [3:0]        auth_ctrl;
  logic              sec_state, bank_sel_en, bank_sel;

  int n_tests = 0;
  int n_fail  = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  dbg_ctl_regs #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_dbg_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .core_halted(core_halted), .core_sleeping(core_sleeping),
    .core_lockup(core_lockup), .sec_dbg_allowed(sec_dbg_allowed),
    .core_reset_evt(core_reset_evt), .core_retire_evt(core_retire_evt),
    .ext_restart_req(ext_restart_req), .xfer_done(xfer_done),
    .xfer_rdata(xfer_rdata), .dbg_en(dbg_en), .halt_req(halt_req),
    .step_en(step_en), .mask_irq(mask_irq), .imprecise_en(imprecise_en),
    .xfer_start(xfer_start), .xfer_wr(xfer_wr), .xfer_sel(xfer_sel),
    .xfer_wdata(xfer_wdata), .mon_ctrl(mon_ctrl), .auth_ctrl(auth_ctrl),
    .sec_state(sec_state), .bank_sel_en(bank_sel_en), .bank_sel(bank_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    #1;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
    #1;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; bus_re = 1'b0;
    core_halted = 1'b0; core_sleeping = 1'b0; core_lockup = 1'b0;
    sec_dbg_allowed = 1'b0; core_reset_evt = 1'b0; core_retire_evt = 1'b0;
    ext_restart_req = 1'b0; xfer_done = 1'b0; xfer_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(8'h10, rd);
    chk("R1 halt word", rd, 32'h0);
    chk("R1 outputs", {26'd0, dbg_en, halt_req, step_en, mask_irq, imprecise_en, xfer_start},
        32'h0);
    chk("R1 aux outputs", mon_ctrl | {28'd0, auth_ctrl} | {31'd0, sec_state} | xfer_wdata, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) bus_write(VECS[i].addr, VECS[i].wdata);
      bus_read(VECS[i].addr, rd);
      chk($sformatf("R%0d row %0d", VECS[i].req, i), rd, VECS[i].exp);
    end
    chk("R9 mon output", mon_ctrl, 32'h010F_0FF1);
    chk("R10 auth output", {28'd0, auth_ctrl}, 32'hF);
    chk("R11 sec outputs", {29'd0, sec_state, bank_sel, bank_sel_en}, 32'h4);

    // R4 live status
    core_halted = 1'b1; core_sleeping = 1'b1; core_lockup = 1'b1; sec_dbg_allowed = 1'b1;
    bus_read(8'h10, rd);
    chk("R4 live status", rd, 32'h001E_0000);
    core_halted = 1'b0; core_sleeping = 1'b0; core_lockup = 1'b0; sec_dbg_allowed = 1'b0;

    // R5 reset flag sticky, clear on read
    pulse(core_reset_evt);
    bus_read(8'h10, rd);
    chk("R5 reset seen", rd, 32'h0200_0000);
    bus_read(8'h10, rd);
    chk("R5 reset cleared", rd, 32'h0);

    // R5 retire event in the same cycle as the read
    @(negedge clk);
    bus_addr = 8'h10; bus_re = 1'b1; core_retire_evt = 1'b1;
    #1 rd = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0; core_retire_evt = 1'b0;
    chk("R5 coincident read", rd, 32'h0);
    bus_read(8'h10, rd);
    chk("R5 coincident kept", rd, 32'h0100_0000);

    // R3 / R6 external restart
    bus_write(8'h10, 32'hA05F_0003);
    chk("R3 outputs", {30'd0, halt_req, dbg_en}, 32'h3);
    pulse(ext_restart_req);
    chk("R6 halt cleared", {30'd0, halt_req, dbg_en}, 32'h1);
    bus_read(8'h10, rd);
    chk("R6 restart seen", rd, 32'h0400_0001);

    // R7 / R8 write-direction transfer
    bus_write(8'h14, 32'h0001_0005);
    chk("R7 start wr", {23'd0, xfer_start, xfer_wr, xfer_sel}, {23'd0, 1'b1, 1'b1, 7'd5});
    @(negedge clk); #1;
    chk("R7 start one cycle", {31'd0, xfer_start}, 32'h0);
    bus_read(8'h10, rd);
    chk("R7 ready cleared", rd, 32'h0000_0001);
    xfer_rdata = 32'hDEAD_BEEF;
    pulse(xfer_done);
    bus_read(8'h18, rd);
    chk("R8 write dir keeps data", rd, 32'h1234_5678);
    chk("R8 write data out", xfer_wdata, 32'h1234_5678);
    bus_read(8'h10, rd);
    chk("R8 ready set", rd, 32'h0001_0001);

    // R7 / R8 read-direction transfer
    bus_write(8'h14, 32'h0000_007F);
    chk("R7 start rd", {23'd0, xfer_start, xfer_wr, xfer_sel}, {23'd0, 1'b1, 1'b0, 7'h7F});
    bus_read(8'h10, rd);
    chk("R7 ready cleared again", rd, 32'h0000_0001);
    xfer_rdata = 32'hCAFE_F00D;
    pulse(xfer_done);
    bus_read(8'h18, rd);
    chk("R8 read dir loads", rd, 32'hCAFE_F00D);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule